// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins an A bus and a B bus through a set of independent byte-wide channels (two channels of eight bits by default). Each channel carries traffic in both directions, and each direction owns a holding register, a capture clock, a source select and an output enable. The driven side of a direction carries either the live value arriving from the opposite bus or the value last captured into that direction's holding register.

Capture happens on the rising edge of the direction's own capture clock. It does not depend on the select or enable inputs, so a bus can be sampled while every driver is off. The buses are modelled as split pins: an input value, an output value and a per-channel drive enable for each side. Each output is computed only from the opposite side's input pins, so enabling both directions in live mode forms no loop. The source select is decoded into two exclusive route enables that gate an and-or merge. There is no priority mux whose select path could race the data path.

The block has no data stream with flow control. Every pin is a plain level or an edge. Outputs follow their inputs combinationally, and the only state is the holding registers.

Top module: `regbus_xcvr`

## Requirements
- R1: Channel c uses bits [8c+7:8c] of each bus and only its own control bits c. Pulses, selects or enables on one channel leave the other channel's outputs and held values unchanged.
- R2: On a rising edge of `cap_ab_clk[c]`, the channel's A-to-B register loads `a_in` for that channel. On a rising edge of `cap_ba_clk[c]`, the B-to-A register loads `b_in`. Both registers may load in the same cycle.
- R3: A capture takes place whatever the values of the selects and enables, including when both drivers of the channel are off.
- R4: A select of 0 (live) puts the opposite bus input on the driven side, in the same cycle, with no register in the path.
- R5: A select of 1 (held) puts the direction's register contents on the driven side. Later changes on the opposite bus input do not alter it until the next capture.
- R6: `ab_en[c]`=1 sets `b_drv[c]`=1, and `ba_en_n[c]`=0 sets `a_drv[c]`=1. A side whose driver is off has its drive bit at 0 and its output value at all zeros.
- R7: With both directions enabled and both selects at 0, `b_out` equals `a_in` and `a_out` equals `b_in` for that channel.
- R8: With `HAS_RST`=1, a capture edge that arrives while `rst`=1 loads zero into that register. Held-mode output after such an edge is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous clear, sampled on each capture clock edge |
| cap_ab_clk | input | NUM_CH | Per-channel capture clock for the A-to-B register |
| cap_ba_clk | input | NUM_CH | Per-channel capture clock for the B-to-A register |
| ab_en | input | NUM_CH | Active-high enable of the B-side drivers |
| ba_en_n | input | NUM_CH | Active-low enable of the A-side drivers |
| ab_src | input | NUM_CH | A-to-B source: 0 live, 1 held |
| ba_src | input | NUM_CH | B-to-A source: 0 live, 1 held |
| a_in | input | NUM_CH*CH_W | Value present on the A bus |
| b_in | input | NUM_CH*CH_W | Value present on the B bus |
| a_out | output | NUM_CH*CH_W | Value driven onto the A bus |
| a_drv | output | NUM_CH | Per-channel A-side driver enable |
| b_out | output | NUM_CH*CH_W | Value driven onto the B bus |
| b_drv | output | NUM_CH | Per-channel B-side driver enable |

## Verification
Changes to a select, an enable or a bus input reach the outputs in the same cycle, with zero register delay. A captured value first appears on a held-mode output right after the capture edge that loads it. The bench changes every input and raises every capture clock on the falling edge of its own 250 MHz clock. Its behavioural model applies each capture at the moment the clock bit rises, and it compares every output of every channel against the model on each following rising edge, so every comparison sees settled values.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source chosen for one direction of a channel.
  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_e;

  // Controls for one direction, after polarity is normalised.
  typedef struct packed {
    logic drive_en;
    src_e src;
  } dir_ctl_t;

endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
  parameter int W       = 8,
  parameter bit HAS_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end

      // R8: a capture edge seen during reset leaves zero behind
      a_r8_reset_zero: assert property (@(posedge clk) rst |=> (q == '0));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        q <= d;
      end
    end
  endgenerate

  // R2: after each capture edge outside reset, q holds the sampled input
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (q == $past(d)));

endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  dir_ctl_t     ctl,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] out,
  output logic         drv
);

  logic route_live;
  logic route_held;

  // Two exclusive route enables gate an and-or merge, so the select
  // never feeds a priority chain that could pass a stale mix.
  always_comb begin
    route_live = ctl.drive_en & (ctl.src == SRC_LIVE);
    route_held = ctl.drive_en & (ctl.src == SRC_HELD);
    out        = ({W{route_live}} & live) | ({W{route_held}} & held);
    drv        = ctl.drive_en;
  end

  // R5: held routing shows the register contents from the hold module
  always_comb begin
    if (ctl.drive_en && ctl.src == SRC_HELD)
      a_r5_held_route: assert (out == held);
  end

  // R6: a disabled side presents all zeros
  always_comb begin
    if (!ctl.drive_en)
      a_r6_idle_zero: assert (out == '0 && !drv);
  end

endmodule

// File: rtl/xcvr_channel.sv
module xcvr_channel
  import xcvr_pkg::*;
#(
  parameter int W       = 8,
  parameter bit HAS_RST = 1'b1
) (
  input  logic         rst,
  input  logic         cap_ab_clk,
  input  logic         cap_ba_clk,
  input  logic         ab_en,
  input  logic         ba_en_n,
  input  logic         ab_src,
  input  logic         ba_src,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  output logic [W-1:0] b_out,
  output logic         b_drv
);

  logic [W-1:0] held_ab;
  logic [W-1:0] held_ba;
  dir_ctl_t     ctl_ab;
  dir_ctl_t     ctl_ba;

  always_comb begin
    ctl_ab.drive_en = ab_en;
    ctl_ab.src      = src_e'(ab_src);
    ctl_ba.drive_en = ~ba_en_n;
    ctl_ba.src      = src_e'(ba_src);
  end

  xcvr_hold_reg #(.W(W), .HAS_RST(HAS_RST)) u_hold_ab (
    .clk (cap_ab_clk),
    .rst (rst),
    .d   (a_in),
    .q   (held_ab)
  );

  xcvr_hold_reg #(.W(W), .HAS_RST(HAS_RST)) u_hold_ba (
    .clk (cap_ba_clk),
    .rst (rst),
    .d   (b_in),
    .q   (held_ba)
  );

  // Each path reads only the opposite side's input pins, never a driven value.
  xcvr_dir_path #(.W(W)) u_path_ab (
    .ctl  (ctl_ab),
    .live (a_in),
    .held (held_ab),
    .out  (b_out),
    .drv  (b_drv)
  );

  xcvr_dir_path #(.W(W)) u_path_ba (
    .ctl  (ctl_ba),
    .live (b_in),
    .held (held_ba),
    .out  (a_out),
    .drv  (a_drv)
  );

  // R7: both directions live and enabled, each side mirrors the other input
  always_comb begin
    if (ab_en && !ba_en_n && !ab_src && !ba_src)
      a_r7_no_loop: assert (b_out == a_in && a_out == b_in);
  end

  // R4: live routing is transparent in the A-to-B direction
  always_comb begin
    if (ab_en && !ab_src)
      a_r4_live_ab: assert (b_out == a_in);
  end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int NUM_CH  = 2,
  parameter int CH_W    = 8,
  parameter bit HAS_RST = 1'b1,
  localparam int BUS_W  = NUM_CH * CH_W
) (
  input  logic              rst,
  input  logic [NUM_CH-1:0] cap_ab_clk,
  input  logic [NUM_CH-1:0] cap_ba_clk,
  input  logic [NUM_CH-1:0] ab_en,
  input  logic [NUM_CH-1:0] ba_en_n,
  input  logic [NUM_CH-1:0] ab_src,
  input  logic [NUM_CH-1:0] ba_src,
  input  logic [BUS_W-1:0]  a_in,
  input  logic [BUS_W-1:0]  b_in,
  output logic [BUS_W-1:0]  a_out,
  output logic [NUM_CH-1:0] a_drv,
  output logic [BUS_W-1:0]  b_out,
  output logic [NUM_CH-1:0] b_drv
);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      xcvr_channel #(.W(CH_W), .HAS_RST(HAS_RST)) u_ch (
        .rst        (rst),
        .cap_ab_clk (cap_ab_clk[c]),
        .cap_ba_clk (cap_ba_clk[c]),
        .ab_en      (ab_en[c]),
        .ba_en_n    (ba_en_n[c]),
        .ab_src     (ab_src[c]),
        .ba_src     (ba_src[c]),
        .a_in       (a_in[c*CH_W +: CH_W]),
        .b_in       (b_in[c*CH_W +: CH_W]),
        .a_out      (a_out[c*CH_W +: CH_W]),
        .a_drv      (a_drv[c]),
        .b_out      (b_out[c*CH_W +: CH_W]),
        .b_drv      (b_drv[c])
      );
    end
  endgenerate

  // R6: drive bits follow the per-channel enables with their polarities
  always_comb begin
    a_r6_drv_polarity: assert (b_drv == ab_en && a_drv == ~ba_en_n);
  end

endmodule

// File: tb/sim_regbus_xcvr.sv
module sim_regbus_xcvr;

  localparam int NCH = 2;
  localparam int CW  = 8;
  localparam int BW  = NCH * CW;

  logic          clk = 1'b0;
  logic          rst;
  logic [NCH-1:0] cap_ab_clk, cap_ba_clk, ab_en, ba_en_n, ab_src, ba_src;
  logic [BW-1:0]  a_in, b_in, a_out, b_out;
  logic [NCH-1:0] a_drv, b_drv;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cycles  = 0;
  bit    run     = 1'b0;
  bit    done    = 1'b0;
  string tag     = "R6";

  logic [CW-1:0] m_ab [NCH];
  logic [CW-1:0] m_ba [NCH];

  always #2 clk = ~clk;

  regbus_xcvr u0 (
    .rst(rst), .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk),
    .ab_en(ab_en), .ba_en_n(ba_en_n), .ab_src(ab_src), .ba_src(ba_src),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_drv(a_drv),
    .b_out(b_out), .b_drv(b_drv)
  );

  // Behavioural reference, compared on every rising edge.
  always @(posedge clk) begin
    if (run && !done) begin
      for (int c = 0; c < NCH; c++) begin
        logic [CW-1:0] eb, ea;
        logic          db, da;
        db = ab_en[c];
        da = !ba_en_n[c];
        eb = !db ? '0 : (ab_src[c] ? m_ab[c] : a_in[c*CW +: CW]);
        ea = !da ? '0 : (ba_src[c] ? m_ba[c] : b_in[c*CW +: CW]);
        n_tests++;
        if (b_out[c*CW +: CW] !== eb || a_out[c*CW +: CW] !== ea ||
            b_drv[c] !== db || a_drv[c] !== da) begin
          n_fail++;
          $display("FAIL %s ch%0d: b_out=%h b_drv=%b a_out=%h a_drv=%b expected %h %b %h %b",
                   tag, c, b_out[c*CW +: CW], b_drv[c], a_out[c*CW +: CW], a_drv[c],
                   eb, db, ea, da);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Raise the chosen capture clocks together; model loads at the same moment.
  task automatic capture(input logic [NCH-1:0] ab, input logic [NCH-1:0] ba);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (ab[c]) m_ab[c] = rst ? '0 : a_in[c*CW +: CW];
      if (ba[c]) m_ba[c] = rst ? '0 : b_in[c*CW +: CW];
    end
    cap_ab_clk = ab;
    cap_ba_clk = ba;
    @(negedge clk);
    cap_ab_clk = '0;
    cap_ba_clk = '0;
  endtask

  initial begin
    rst = 1'b1; cap_ab_clk = '0; cap_ba_clk = '0;
    ab_en = '0; ba_en_n = '1; ab_src = '0; ba_src = '0;
    a_in = '0; b_in = '0;
    for (int c = 0; c < NCH; c++) begin m_ab[c] = '0; m_ba[c] = '0; end
    run = 1'b1;
    wait_n(2);

    // R8: capture during reset clears both registers
    tag = "R8";
    a_in = 16'hFFFF; b_in = 16'hEEEE;
    capture('1, '1);
    @(negedge clk);
    rst = 1'b0; ab_src = '1; ba_src = '1; ab_en = '1; ba_en_n = '0;
    wait_n(3);

    // R4: live transfer, one direction at a time
    tag = "R4";
    ab_src = '0; ba_src = '0; ba_en_n = '1;
    a_in = 16'hA55A; wait_n(2);
    a_in = 16'h0FF0; wait_n(2);
    ab_en = '0; ba_en_n = '0;
    b_in = 16'h1234; wait_n(2);
    b_in = 16'h8001; wait_n(2);

    // R2 and R5: capture both directions at once, then hold
    tag = "R2";
    a_in = 16'hC33C; b_in = 16'h5AA5;
    capture('1, '1);
    tag = "R5";
    ab_en = '1; ba_en_n = '0; ab_src = '1; ba_src = '1;
    a_in = 16'h0000; b_in = 16'hFFFF; wait_n(3);
    a_in = 16'h7E81; wait_n(2);

    // R3: capture while both drivers are off and selects are live
    tag = "R3";
    ab_en = '0; ba_en_n = '1; ab_src = '0; ba_src = '0;
    a_in = 16'h3C96; b_in = 16'hD00D;
    capture('1, '1);
    a_in = 16'h1111; b_in = 16'h2222;
    @(negedge clk);
    ab_en = '1; ba_en_n = '0; ab_src = '1; ba_src = '1;
    wait_n(3);

    // R7: both directions enabled in live mode
    tag = "R7";
    ab_src = '0; ba_src = '0;
    a_in = 16'h4B2D; b_in = 16'hE718; wait_n(2);
    a_in = 16'hFF00; b_in = 16'h00FF; wait_n(2);

    // R1: only channel 0 captures; channel 1 keeps its old held values
    tag = "R1";
    ab_src = '1; ba_src = '1;
    a_in = 16'h6699; b_in = 16'h9966;
    capture(2'b01, 2'b01);
    wait_n(2);
    ab_src = 2'b10; ba_src = 2'b01; ab_en = 2'b01; ba_en_n = 2'b10;
    a_in = 16'hABCD; b_in = 16'h1357; wait_n(3);
    capture(2'b10, 2'b00);
    ab_en = '1; ab_src = '1; wait_n(2);

    // R6: all drivers off
    tag = "R6";
    ab_en = '0; ba_en_n = '1; wait_n(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule